// File: doc/BRIEF.md
# SD Host Command and Interrupt Control

This block is the register-side controller of an SD/MMC host. Software reaches it through a 32-bit memory-mapped register port with a combinational read path. Through this port software loads a command argument, the interrupt mask and a few storage registers. It then writes the command word with the start bit set. The block holds the command fields steady on a card-side request port until the card-side engine answers with a one-cycle done strobe and four response words.

On completion the block clears the start bit and latches the responses. It then sets status bits chosen by the kind of command, the transfer direction and the interrupt mask that is in force at that moment. The raw status bits are cleared by writing ones to them. The interrupt output is a level that is high whenever a masked status bit is set. A write to a control bit performs a soft reset of the command-side state.

Top module: `sdhc_cmd_ctrl`

## Requirements
- R1: The command word (offset 0x18) holds the command index in bits 5:0, the expect-response flag in bit 6, the data-transfer flag in bit 9, the direction in bit 10 (1 = write to card) and the init-sequence flag in bit 15. Writing it with bit 31 set raises `card_req` and drives these fields and the argument on the card port. Bit 31 reads back as 1 while the command is outstanding.
- R2: A `card_done` pulse while a command is outstanding clears bit 31 and drops `card_req` in the following cycle. In the same cycle the four response words are latched from `card_resp` (word i from bits 32i+31:32i) into offsets 0x20, 0x24, 0x28 and 0x2C.
- R3: A write to the command word while a command is outstanding is ignored. The stored fields and the card port do not change.
- R4: In the raw status (offset 0x38), writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R5: The masked status (offset 0x34) reads raw AND mask (mask at offset 0x30). `irq` is high exactly when that value is nonzero.
- R6: When a data command completes, DMA status (offset 0x88) bit 0 is set if the direction is write-to-card and bit 1 is set otherwise. Both bits are cleared by writing 1 to them.
- R7: When a data command completes, raw bit 3 is set if mask bit 3 is 1. Otherwise raw bit 14 is set if mask bit 14 is 1. Otherwise no raw bit is set.
- R8: When a non-data command completes with the response or init flag set, raw bit 2 is set. Raw bit 8 is also set for command indices 1, 5 and 52. With neither flag set, no raw bit is set.
- R9: After reset the block-size register (offset 0x10) reads 0x200. Every other register reads 0, and `irq` and `card_req` are low.
- R10: Writing 1 to control (offset 0x00) bit 0 clears the mask, the argument, the descriptor base (offset 0x84), the command word and DMA status, and the control register reads 0 afterwards. The raw status and the block size are kept.
- R11: These registers read back what was written: argument (0x1C), descriptor base (0x84), byte count (0x14), DMA interrupt enable (0x8C), block size (0x10, bits 15:0 only) and control bits 2, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| card_req | output | 1 | Command outstanding to the card side |
| card_idx | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| card_init | output | 1 | Init sequence requested |
| card_data | output | 1 | Command carries a data transfer |
| card_dir_wr | output | 1 | Data direction, 1 = write to card |
| card_resp_exp | output | 1 | Response expected |
| card_done | input | 1 | One-cycle completion strobe |
| card_resp | input | 128 | Four response words, word 0 in the low bits |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the handshake timing and the status rules on every cycle. After a done pulse the start bit must fall, a busy command must hold its fields, a raw write must clear its ones, and each kind of completion must leave its status bit set. Some behaviours show only in the bench's scenarios. These are the fallback from bit 3 to bit 14 and to no bit at all, the extra bit for the three special indices, the soft-reset scope, and the exact register values seen through the read port.

// File: rtl/sdhc_pkg.sv
package sdhc_pkg;
  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_BLKSZ   = 12'h010;
  localparam logic [11:0] OFS_BYTECNT = 12'h014;
  localparam logic [11:0] OFS_CMD     = 12'h018;
  localparam logic [11:0] OFS_ARG     = 12'h01C;
  localparam logic [11:0] OFS_RESP0   = 12'h020;
  localparam logic [11:0] OFS_MASK    = 12'h030;
  localparam logic [11:0] OFS_MSTAT   = 12'h034;
  localparam logic [11:0] OFS_RAW     = 12'h038;
  localparam logic [11:0] OFS_DESC    = 12'h084;
  localparam logic [11:0] OFS_DMAST   = 12'h088;
  localparam logic [11:0] OFS_DMAIE   = 12'h08C;

  localparam int CB_START = 31;
  localparam int CB_INIT  = 15;
  localparam int CB_DIR   = 10;
  localparam int CB_DATA  = 9;
  localparam int CB_RESP  = 6;

  localparam int IB_CMD_DONE  = 2;
  localparam int IB_XFER_DONE = 3;
  localparam int IB_OPCOND    = 8;
  localparam int IB_AUTO_DONE = 14;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_0034;
  localparam logic [15:0] BLKSZ_RESET = 16'h0200;

  typedef struct packed {
    logic       init;
    logic       dir_wr;
    logic       data;
    logic       resp;
    logic [5:0] idx;
  } cmd_t;

  function automatic logic is_opcond(input logic [5:0] idx);
    return (idx == 6'd1) || (idx == 6'd5) || (idx == 6'd52);
  endfunction
endpackage

// File: rtl/sdhc_cmd_seq.sv
module sdhc_cmd_seq
  import sdhc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RESP_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_wr,
  input  logic [DW-1:0]            wdata,
  input  logic                     soft_rst,
  input  logic                     card_done,
  input  logic [RESP_WORDS*DW-1:0] card_resp,
  output cmd_t                     cmd_q,
  output logic                     busy_q,
  output logic                     cpl,
  output logic [DW-1:0]            cmd_rd,
  output logic [RESP_WORDS*DW-1:0] resp_q
);
  cmd_t cmd_d;
  logic busy_d;

  assign cpl = busy_q && card_done && !soft_rst;

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    if (soft_rst) begin
      cmd_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (card_done) busy_d = 1'b0;
    end else if (cmd_wr) begin
      cmd_d.init   = wdata[CB_INIT];
      cmd_d.dir_wr = wdata[CB_DIR];
      cmd_d.data   = wdata[CB_DATA];
      cmd_d.resp   = wdata[CB_RESP];
      cmd_d.idx    = wdata[5:0];
      busy_d       = wdata[CB_START];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
    end
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_resp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   resp_q[w*DW +: DW] <= '0;
      else if (cpl) resp_q[w*DW +: DW] <= card_resp[w*DW +: DW];
    end
  end

  always_comb begin
    cmd_rd           = '0;
    cmd_rd[CB_START] = busy_q;
    cmd_rd[CB_INIT]  = cmd_q.init;
    cmd_rd[CB_DIR]   = cmd_q.dir_wr;
    cmd_rd[CB_DATA]  = cmd_q.data;
    cmd_rd[CB_RESP]  = cmd_q.resp;
    cmd_rd[5:0]      = cmd_q.idx;
  end

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && card_done |=> !busy_q);
  p_resp_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpl |=> resp_q == $past(card_resp));
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !card_done && !soft_rst |=> busy_q && $stable(cmd_q));
endmodule

// File: rtl/sdhc_irq_stat.sv
module sdhc_irq_stat
  import sdhc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          mask_wr,
  input  logic          raw_wr,
  input  logic          dmast_wr,
  input  logic [DW-1:0] wdata,
  input  logic          cpl,
  input  cmd_t          cmd,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] raw_q,
  output logic [1:0]    dmast_q,
  output logic          irq
);
  logic [DW-1:0] mask_d, raw_d, raw_set, raw_clr;
  logic [1:0]    dma_d, dma_set, dma_clr;

  always_comb begin
    raw_set = '0;
    dma_set = '0;
    if (cpl) begin
      if (cmd.data) begin
        if (cmd.dir_wr) dma_set[0] = 1'b1;
        else            dma_set[1] = 1'b1;
        if (mask_q[IB_XFER_DONE])      raw_set[IB_XFER_DONE] = 1'b1;
        else if (mask_q[IB_AUTO_DONE]) raw_set[IB_AUTO_DONE] = 1'b1;
      end else if (cmd.resp || cmd.init) begin
        raw_set[IB_CMD_DONE] = 1'b1;
        if (is_opcond(cmd.idx)) raw_set[IB_OPCOND] = 1'b1;
      end
    end
  end

  always_comb begin
    raw_clr = raw_wr   ? wdata      : '0;
    dma_clr = dmast_wr ? wdata[1:0] : 2'b00;
    raw_d   = (raw_q & ~raw_clr) | raw_set;
    if (soft_rst) begin
      mask_d = '0;
      dma_d  = '0;
    end else begin
      mask_d = mask_wr ? wdata : mask_q;
      dma_d  = (dmast_q & ~dma_clr) | dma_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      raw_q   <= '0;
      dmast_q <= '0;
    end else begin
      mask_q  <= mask_d;
      raw_q   <= raw_d;
      dmast_q <= dma_d;
    end
  end

  assign irq = |(raw_q & mask_q);

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_wr && !cpl |=> (raw_q & $past(wdata)) == '0);
  p_dma_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl && cmd.data |=> dmast_q != 2'b00);
  p_xfer_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl && cmd.data && mask_q[IB_XFER_DONE] && !mask_wr |=> raw_q[IB_XFER_DONE]);
  p_cmd_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl && !cmd.data && (cmd.resp || cmd.init) |=> raw_q[IB_CMD_DONE]);
endmodule

// File: rtl/sdhc_cmd_ctrl.sv
module sdhc_cmd_ctrl
  import sdhc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 12,
  parameter int RESP_WORDS = 4,
  parameter int BLK_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     card_req,
  output logic [5:0]               card_idx,
  output logic [DW-1:0]            card_arg,
  output logic                     card_init,
  output logic                     card_data,
  output logic                     card_dir_wr,
  output logic                     card_resp_exp,
  input  logic                     card_done,
  input  logic [RESP_WORDS*DW-1:0] card_resp,
  output logic                     irq
);
  localparam int BYTES = DW / 8;

  logic soft_rst, wr_ctrl, wr_blk, wr_cnt, wr_cmd, wr_arg, wr_mask, wr_raw, wr_desc, wr_dmast, wr_dmaie;
  logic [DW-1:0]    ctrl_q, ctrl_d, cnt_q, cnt_d, arg_q, arg_d, desc_q, desc_d, dmaie_q, dmaie_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  cmd_t             cmd_q;
  logic             busy_q, cpl;
  logic [DW-1:0]    cmd_rd, mask_q, raw_q;
  logic [1:0]       dmast_q;
  logic [RESP_WORDS*DW-1:0] resp_q;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_blk   = bus_wr && (bus_addr == OFS_BLKSZ);
  assign wr_cnt   = bus_wr && (bus_addr == OFS_BYTECNT);
  assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
  assign wr_arg   = bus_wr && (bus_addr == OFS_ARG);
  assign wr_mask  = bus_wr && (bus_addr == OFS_MASK);
  assign wr_raw   = bus_wr && (bus_addr == OFS_RAW);
  assign wr_desc  = bus_wr && (bus_addr == OFS_DESC);
  assign wr_dmast = bus_wr && (bus_addr == OFS_DMAST);
  assign wr_dmaie = bus_wr && (bus_addr == OFS_DMAIE);
  assign soft_rst = wr_ctrl && bus_wdata[0];

  always_comb begin
    ctrl_d  = ctrl_q;
    blk_d   = wr_blk   ? bus_wdata[BLK_W-1:0] : blk_q;
    cnt_d   = wr_cnt   ? bus_wdata : cnt_q;
    dmaie_d = wr_dmaie ? bus_wdata : dmaie_q;
    arg_d   = wr_arg   ? bus_wdata : arg_q;
    desc_d  = wr_desc  ? bus_wdata : desc_q;
    if (soft_rst) begin
      ctrl_d = '0;
      arg_d  = '0;
      desc_d = '0;
    end else if (wr_ctrl) begin
      ctrl_d = bus_wdata & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      blk_q   <= BLKSZ_RESET[BLK_W-1:0];
      cnt_q   <= '0;
      arg_q   <= '0;
      desc_q  <= '0;
      dmaie_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      blk_q   <= blk_d;
      cnt_q   <= cnt_d;
      arg_q   <= arg_d;
      desc_q  <= desc_d;
      dmaie_q <= dmaie_d;
    end
  end

  sdhc_cmd_seq #(.DW(DW), .RESP_WORDS(RESP_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .wdata(bus_wdata), .soft_rst(soft_rst),
    .card_done(card_done), .card_resp(card_resp), .cmd_q(cmd_q), .busy_q(busy_q),
    .cpl(cpl), .cmd_rd(cmd_rd), .resp_q(resp_q)
  );

  sdhc_irq_stat #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mask_wr(wr_mask), .raw_wr(wr_raw),
    .dmast_wr(wr_dmast), .wdata(bus_wdata), .cpl(cpl), .cmd(cmd_q),
    .mask_q(mask_q), .raw_q(raw_q), .dmast_q(dmast_q), .irq(irq)
  );

  assign card_req      = busy_q;
  assign card_idx      = cmd_q.idx;
  assign card_arg      = arg_q;
  assign card_init     = cmd_q.init;
  assign card_data     = cmd_q.data;
  assign card_dir_wr   = cmd_q.dir_wr;
  assign card_resp_exp = cmd_q.resp;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:    bus_rdata = ctrl_q;
      OFS_BLKSZ:   bus_rdata = DW'(blk_q);
      OFS_BYTECNT: bus_rdata = cnt_q;
      OFS_CMD:     bus_rdata = cmd_rd;
      OFS_ARG:     bus_rdata = arg_q;
      OFS_MASK:    bus_rdata = mask_q;
      OFS_MSTAT:   bus_rdata = raw_q & mask_q;
      OFS_RAW:     bus_rdata = raw_q;
      OFS_DESC:    bus_rdata = desc_q;
      OFS_DMAST:   bus_rdata = DW'(dmast_q);
      OFS_DMAIE:   bus_rdata = dmaie_q;
      default:     bus_rdata = '0;
    endcase
    for (int w = 0; w < RESP_WORDS; w++) begin
      if (bus_addr == AW'(int'(OFS_RESP0) + w * BYTES)) bus_rdata = resp_q[w*DW +: DW];
    end
  end

  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !card_req && mask_q == '0 && arg_q == '0 && dmast_q == 2'b00);
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q & mask_q) != '0);
endmodule

// File: tb/sim_sdhc_cmd_ctrl.sv
module sim_sdhc_cmd_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         card_req, card_init, card_data, card_dir_wr, card_resp_exp, irq;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         card_done = 1'b0;
  logic [127:0] card_resp = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdhc_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
    .card_init(card_init), .card_data(card_data), .card_dir_wr(card_dir_wr),
    .card_resp_exp(card_resp_exp), .card_done(card_done), .card_resp(card_resp), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_cmd(input logic [127:0] r);
    @(negedge clk);
    card_resp = r; card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] w);
    wr(12'h018, w);
    finish_cmd('0);
  endtask

  task automatic t_reset;
    rd_chk("R9 blksz", 12'h010, 32'h200);
    rd_chk("R9 cmd", 12'h018, 32'h0);
    rd_chk("R9 raw", 12'h038, 32'h0);
    rd_chk("R9 mask", 12'h030, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    chk("R9 card_req", {31'b0, card_req}, 32'h0);
  endtask

  task automatic t_storage;
    wr(12'h01C, 32'hA5A5_1234);
    wr(12'h084, 32'h8000_0040);
    wr(12'h014, 32'h0000_0400);
    wr(12'h010, 32'h0001_0040);
    wr(12'h08C, 32'hFFFF_0001);
    wr(12'h000, 32'hFFFF_FFFE);
    rd_chk("R11 arg", 12'h01C, 32'hA5A5_1234);
    rd_chk("R11 desc", 12'h084, 32'h8000_0040);
    rd_chk("R11 bytecnt", 12'h014, 32'h400);
    rd_chk("R11 blksz", 12'h010, 32'h40);
    rd_chk("R11 dmaie", 12'h08C, 32'hFFFF_0001);
    rd_chk("R11 ctrl", 12'h000, 32'h34);
  endtask

  task automatic t_nondata;
    wr(12'h030, 32'h104);
    wr(12'h01C, 32'h1234);
    wr(12'h018, 32'h8000_0045);
    chk("R1 req", {31'b0, card_req}, 32'h1);
    chk("R1 idx", {26'b0, card_idx}, 32'h5);
    chk("R1 arg", card_arg, 32'h1234);
    chk("R1 flags", {28'b0, card_init, card_data, card_dir_wr, card_resp_exp}, 32'h1);
    rd_chk("R1 cmd busy", 12'h018, 32'h8000_0045);
    finish_cmd({32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001});
    chk("R2 req low", {31'b0, card_req}, 32'h0);
    rd_chk("R2 cmd done", 12'h018, 32'h0000_0045);
    rd_chk("R2 resp0", 12'h020, 32'hAAAA_0001);
    rd_chk("R2 resp3", 12'h02C, 32'hDDDD_0004);
    rd_chk("R8 raw op", 12'h038, 32'h104);
    rd_chk("R5 masked", 12'h034, 32'h104);
    chk("R5 irq hi", {31'b0, irq}, 32'h1);
    wr(12'h038, 32'h104);
    rd_chk("R4 raw clr", 12'h038, 32'h0);
    chk("R5 irq lo", {31'b0, irq}, 32'h0);
    run_cmd(32'h8000_8011);
    rd_chk("R8 init only", 12'h038, 32'h4);
    wr(12'h038, 32'h4);
    run_cmd(32'h8000_000C);
    rd_chk("R8 no flag", 12'h038, 32'h0);
  endtask

  task automatic t_data;
    wr(12'h030, 32'h8);
    run_cmd(32'h8000_0618);
    rd_chk("R6 tx", 12'h088, 32'h1);
    rd_chk("R7 bit3", 12'h038, 32'h8);
    wr(12'h038, 32'h8);
    wr(12'h088, 32'h1);
    rd_chk("R6 w1c", 12'h088, 32'h0);
    wr(12'h030, 32'h4000);
    run_cmd(32'h8000_0211);
    rd_chk("R6 rx", 12'h088, 32'h2);
    rd_chk("R7 bit14", 12'h038, 32'h4000);
    wr(12'h038, 32'h4000);
    wr(12'h030, 32'h0);
    run_cmd(32'h8000_0611);
    rd_chk("R6 both", 12'h088, 32'h3);
    rd_chk("R7 none", 12'h038, 32'h0);
    wr(12'h088, 32'h1);
    rd_chk("R6 w1c one", 12'h088, 32'h2);
    wr(12'h030, 32'h4008);
    run_cmd(32'h8000_0211);
    rd_chk("R7 prio", 12'h038, 32'h8);
    wr(12'h038, 32'h8);
  endtask

  task automatic t_busy;
    wr(12'h018, 32'h8000_0042);
    wr(12'h018, 32'h8000_0203);
    rd_chk("R3 cmd held", 12'h018, 32'h8000_0042);
    chk("R3 idx held", {26'b0, card_idx}, 32'h2);
    chk("R3 data held", {31'b0, card_data}, 32'h0);
    finish_cmd('0);
    rd_chk("R3 after", 12'h018, 32'h0000_0042);
  endtask

  task automatic t_w1c;
    wr(12'h030, 32'h104);
    run_cmd(32'h8000_0041);
    rd_chk("R8 idx1", 12'h038, 32'h104);
    wr(12'h038, 32'h4);
    rd_chk("R4 partial", 12'h038, 32'h100);
    wr(12'h038, 32'h0);
    rd_chk("R4 zero", 12'h038, 32'h100);
    wr(12'h030, 32'h4);
    rd_chk("R5 masked0", 12'h034, 32'h0);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h030, 32'h100);
    chk("R5 irq unmask", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_soft;
    wr(12'h01C, 32'h77);
    wr(12'h084, 32'h1000);
    wr(12'h010, 32'h80);
    run_cmd(32'h8000_0211);
    wr(12'h018, 32'h0000_0045);
    wr(12'h000, 32'h35);
    rd_chk("R10 mask", 12'h030, 32'h0);
    rd_chk("R10 arg", 12'h01C, 32'h0);
    rd_chk("R10 desc", 12'h084, 32'h0);
    rd_chk("R10 cmd", 12'h018, 32'h0);
    rd_chk("R10 dmast", 12'h088, 32'h0);
    rd_chk("R10 ctrl", 12'h000, 32'h0);
    rd_chk("R10 raw kept", 12'h038, 32'h100);
    rd_chk("R10 blksz kept", 12'h010, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_nondata();
    t_data();
    t_busy();
    t_w1c();
    t_soft();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule